// File: doc/BRIEF.md
# Modulo 2^n+1 multiplier

This unit multiplies two residues modulo M = 2^N+1 that arrive in normal (not diminished-one) representation, each in the range 0 to 2^N. One operand is a data sample and the other is normally a power of the transform kernel. When neither operand is 2^N, the unit forms the full 2N-bit product and splits it into a low N-bit word and a high N-bit word. Because 2^N is congruent to -1, the residue is the low word minus the high word. A single subtraction does this: its carry selects either the bare difference or the difference plus one, which stands in for adding M back.

An operand equal to 2^N is -1 in the ring, so the result is the modular negation of the other operand. A zero operand gives zero directly. The result is N+1 bits wide and covers the whole range 0 to 2^N.

Operands enter on a valid/ready stream and results leave on another. A transfer happens on a rising edge where valid and ready are both high. The producer must hold the operands stable while in_valid is high and in_ready is low. The unit likewise holds out_z while out_valid is high and out_ready is low.

The parameter PIPE selects the timing:
- With PIPE=1, a register sits between the product and the reduction. Latency is one cycle and throughput is one operation per cycle.
- With PIPE=0, the path is purely combinational and the handshake passes straight through.

Top module: `fermat_mul`

## Requirements
- R1: For operands x, y below 2^N, out_z equals (x*y) mod (2^N+1), computed as low word minus high word of the product. For example, with N=4, 15*15 gives 4 and 4*13 gives 1.
- R2: An operand equal to 2^N (bit N set) acts as -1, so out_z = (2^N+1 - other) for a nonzero other operand. The cases 2^N times 0 and 0 times 2^N give 0, and 2^N times 2^N gives 1.
- R3: out_z never exceeds 2^N, and out_z equals 2^N when the true residue is 2^N. For example, with N=4, 8*2 gives 16.
- R4: With PIPE=1, operands accepted on an edge produce out_valid high with their result right after that edge. If nothing is accepted while the output drains, out_valid goes low.
- R5: With PIPE=1, while out_valid is high and out_ready is low, out_valid and out_z hold their values and in_ready is low.
- R6: With PIPE=1 and out_ready high, in_ready is high. A held result then leaves on the same edge that accepts new operands, so the unit sustains one result per cycle in order.
- R7: While rst is high, out_valid is low after the next edge and in_ready is high.
- R8: With PIPE=0, out_valid equals in_valid, in_ready equals out_ready, and out_z is the result for the operands present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit can take an operand pair |
| in_x | input | N+1 | Data operand, 0 to 2^N |
| in_y | input | N+1 | Kernel operand, 0 to 2^N |
| out_valid | output | 1 | out_z carries a result |
| out_ready | input | 1 | Consumer takes the result |
| out_z | output | N+1 | Residue of in_x*in_y mod 2^N+1 |

## Verification
With PIPE=1, handing a finished result to the consumer and capturing a fresh operand pair into the same register can happen on the same edge. The bench provokes this in two ways. First, it streams every operand pair back to back with out_ready held high. Second, it stalls the output with a pair already waiting at the input and then releases out_ready. Each result must appear exactly once, in order, with the residue computed by the bench's own modulo arithmetic. A combinational instance run on the same stimulus must give the same residue in the same cycle it is fed.

// File: rtl/fermat_mul_pkg.sv
package fermat_mul_pkg;
  // how the reduced result is formed
  typedef enum logic [1:0] {
    PICK_FOLD = 2'd0,  // low word minus high word
    PICK_NEG  = 2'd1,  // one operand is -1: negate the other
    PICK_ZERO = 2'd2   // a zero operand
  } pick_e;
endpackage

// File: rtl/mfm_front.sv
module mfm_front
  import fermat_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0]   x,
  input  logic [N:0]   y,
  output pick_e        pick,
  output logic [N-1:0] lo,
  output logic [N-1:0] hi,
  output logic [N:0]   neg_src
);
  localparam logic [N:0] ZERO = '0;
  logic [2*N-1:0] prod;

  always_comb begin
    prod    = {{N{1'b0}}, x[N-1:0]} * {{N{1'b0}}, y[N-1:0]};
    lo      = prod[N-1:0];
    hi      = prod[2*N-1:N];
    neg_src = x[N] ? y : x;
    if (x == ZERO || y == ZERO) pick = PICK_ZERO;
    else if (x[N] || y[N])      pick = PICK_NEG;
    else                        pick = PICK_FOLD;
  end
endmodule

// File: rtl/mfm_stage.sv
module mfm_stage #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (PIPE) begin : g_reg
      logic         full;
      logic [W-1:0] hold;
      always_ff @(posedge clk) begin
        if (rst) begin
          full <= 1'b0;
          hold <= '0;
        end else if (in_ready) begin
          full <= in_valid;
          hold <= in_data;
        end
      end
      assign in_ready  = !full || out_ready;
      assign out_valid = full;
      assign out_data  = hold;
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/mfm_fold.sv
module mfm_fold
  import fermat_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  pick_e        pick,
  input  logic [N-1:0] lo,
  input  logic [N-1:0] hi,
  input  logic [N:0]   neg_src,
  output logic [N:0]   z
);
  localparam logic [N:0] ONE = {{N{1'b0}}, 1'b1};
  localparam logic [N:0] TOP = {1'b1, {N{1'b0}}};
  logic [N:0] diff;
  logic [N:0] base;
  logic [N:0] folded;
  logic [N:0] negated;

  always_comb begin
    // lo - hi as lo + ~hi + 1; carry set means lo >= hi
    diff    = {1'b0, lo} + {1'b0, ~hi} + ONE;
    base    = {1'b0, diff[N-1:0]};
    folded  = diff[N] ? base : base + ONE;
    negated = TOP - neg_src + ONE;
    unique case (pick)
      PICK_FOLD: z = folded;
      PICK_NEG:  z = negated;
      default:   z = '0;
    endcase
  end
endmodule

// File: rtl/fermat_mul.sv
module fermat_mul
  import fermat_mul_pkg::*;
#(
  parameter int N    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [N:0] in_x,
  input  logic [N:0] in_y,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [N:0] out_z
);
  localparam int W = 2 + 2 * N + (N + 1);

  pick_e        f_pick;
  logic [N-1:0] f_lo;
  logic [N-1:0] f_hi;
  logic [N:0]   f_neg;
  logic [W-1:0] s_in;
  logic [W-1:0] s_out;
  pick_e        r_pick;

  mfm_front #(.N(N)) u_front (
    .x(in_x), .y(in_y), .pick(f_pick), .lo(f_lo), .hi(f_hi), .neg_src(f_neg)
  );

  assign s_in = {f_pick, f_lo, f_hi, f_neg};

  mfm_stage #(.W(W), .PIPE(PIPE)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(s_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(s_out)
  );

  assign r_pick = pick_e'(s_out[W-1 -: 2]);

  mfm_fold #(.N(N)) u_fold (
    .pick(r_pick),
    .lo(s_out[W-3 -: N]),
    .hi(s_out[N + N : N + 1]),
    .neg_src(s_out[N:0]),
    .z(out_z)
  );
endmodule

// File: rtl/fermat_mul_chk.sv
module fermat_mul_chk #(
  parameter int N    = 8,
  parameter bit PIPE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [N:0] in_x,
  input logic [N:0] in_y,
  input logic       out_valid,
  input logic       out_ready,
  input logic [N:0] out_z
);
  localparam logic [N:0]     TOP  = {1'b1, {N{1'b0}}};
  localparam logic [2*N+1:0] MODW = {{(N+1){1'b0}}, TOP} + {{(2*N+1){1'b0}}, 1'b1};
  logic [2*N+1:0] ref_mod;
  assign ref_mod = ({{(N+1){1'b0}}, in_x} * {{(N+1){1'b0}}, in_y}) % MODW;

  // R3
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_z <= TOP);

  generate
    if (PIPE) begin : g_seq
      // R1
      mod_match_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_z == $past(ref_mod[N:0]));
      // R2
      neg_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_x == TOP && in_y != '0
        |=> out_z == TOP - $past(in_y) + 1'b1);
      // R4
      accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);
      // R5
      hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_z));
      // R5
      stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
      // R6
      drain_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);
      // R7
      reset_idle_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
    end else begin : g_comb
      // R8
      pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid == in_valid) && (in_ready == out_ready));
      // R8
      comb_match_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> out_z == ref_mod[N:0]);
    end
  endgenerate
endmodule

bind fermat_mul fermat_mul_chk #(.N(N), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
  .out_z(out_z)
);

// File: tb/fermat_mul_bench.sv
`timescale 1ns/1ps
module fermat_mul_bench;
  localparam int N = 4;
  localparam int M = (1 << N) + 1;
  localparam int NV = 12;
  // x, y, expected residue, requirement (1..3)
  localparam int VEC [NV][4] = '{
    '{0, 5, 0, 1}, '{3, 5, 15, 1}, '{16, 16, 1, 2}, '{16, 3, 14, 2},
    '{5, 16, 12, 2}, '{16, 0, 0, 2}, '{0, 16, 0, 2}, '{4, 13, 1, 1},
    '{15, 15, 4, 1}, '{8, 2, 16, 3}, '{1, 16, 16, 3}, '{2, 8, 16, 3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [N:0] in_x = '0;
  logic [N:0] in_y = '0;
  logic p_in_ready, p_out_valid, c_in_ready, c_out_valid;
  logic [N:0] p_z, c_z;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fermat_mul #(.N(N), .PIPE(1'b1)) u_fermat_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(p_in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(p_out_valid), .out_ready(out_ready),
    .out_z(p_z)
  );

  fermat_mul #(.N(N), .PIPE(1'b0)) u_fermat_mul_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_z(c_z)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    if (k == 2) return "R2";
    if (k == 3) return "R3";
    return "R1";
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int prev_exp;
    bit prev_has;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 out_valid", p_out_valid, 0);
    chk("R7 in_ready", p_in_ready, 1);
    rst = 1'b0;

    // vector table, streamed back to back
    prev_has = 1'b0;
    prev_exp = 0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_x = (N+1)'(VEC[i][0]);
      in_y = (N+1)'(VEC[i][1]);
      #1;
      chk({"R8 ", tag_of(VEC[i][3])}, int'(c_z), VEC[i][2]);
      if (prev_has) begin
        chk("R4 valid", p_out_valid, 1);
        chk({"R6 ", tag_of(VEC[i-1][3])}, int'(p_z), prev_exp);
      end
      prev_exp = VEC[i][2];
      prev_has = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R6 last", int'(p_z), prev_exp);
    chk("R8 valid", c_out_valid, 0);
    @(negedge clk);
    chk("R4 drained", p_out_valid, 0);

    // exhaustive, streamed back to back
    prev_has = 1'b0;
    for (int x = 0; x < M; x++) begin
      for (int y = 0; y < M; y++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_x = (N+1)'(x);
        in_y = (N+1)'(y);
        #1;
        chk((x == M - 1 || y == M - 1) ? "R2 comb" : "R1 comb", int'(c_z), (x * y) % M);
        if (prev_has) chk("R1 pipe", int'(p_z), prev_exp);
        prev_exp = (x * y) % M;
        prev_has = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R1 pipe last", int'(p_z), prev_exp);
    @(negedge clk);

    // stall with a waiting input, then release
    in_valid = 1'b1; in_x = 5'd3; in_y = 5'd5; out_ready = 1'b1;
    @(negedge clk);
    in_x = 5'd4; in_y = 5'd13; out_ready = 1'b0;
    #1;
    chk("R5 valid", p_out_valid, 1);
    chk("R5 z", int'(p_z), 15);
    chk("R5 in_ready", p_in_ready, 0);
    chk("R8 in_ready", c_in_ready, 0);
    @(negedge clk);
    #1;
    chk("R5 z held", int'(p_z), 15);
    chk("R5 valid held", p_out_valid, 1);
    out_ready = 1'b1;
    #1;
    chk("R6 in_ready", p_in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R6 next z", int'(p_z), 1);
    chk("R6 next valid", p_out_valid, 1);
    @(negedge clk);
    chk("R4 idle", p_out_valid, 0);

    // reset while holding a result
    in_valid = 1'b1; in_x = 5'd8; in_y = 5'd2; out_ready = 1'b0;
    @(negedge clk);
    chk("R3 top value", int'(p_z), 16);
    rst = 1'b1;
    @(negedge clk);
    chk("R7 flush", p_out_valid, 0);
    in_valid = 1'b0;
    rst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule